// File: doc/BRIEF.md
# Synchronous memory clock generator

This block derives the clock for an attached synchronous memory from the faster functional clock. The divide ratio is 1, 2, 3 or 4, and the output always has an even 50% high/low split. The output toggles only while a synchronous access is in progress. Each access is opened by a one-cycle start pulse. That pulse captures the whole configuration: the sync/async flag, divide select, activation delay, cycle time and page time.

The output clock stays low until the programmed activation delay has elapsed. At that point the divider phase starts from zero, so the first output rising edge always lands on the activation cycle. When the access cycle time runs out, the output is forced low, even in the middle of a high phase, and it stays low until the next start. A companion pulse marks the functional cycle in which each output rising edge occurs, for use by capture logic. A configuration error flag reports a cycle time or page time that does not fit a whole number of output periods.

Top module: `sync_mem_clk_gen`

## Requirements
- R1: With divide select d (0..3) and N = d+1, the running output is high for N functional half-periods and then low for N, repeating. The encodings are: d=0 gives the functional clock itself during its high half; d=1 gives 1 cycle high and 1 low; d=2 gives 1.5 cycles high and 1.5 low; d=3 gives 2 cycles high and 2 low.
- R2: When the sync flag is 0 at the start pulse, the output clock stays low and no edge pulse occurs for the whole access.
- R3: With activation delay a (0..3), the first output rising edge coincides with the a-th functional rising edge after the edge that samples the start pulse. For a=0 it coincides with that same edge.
- R4: Let C be the cycle time captured at start. From the C-th functional rising edge after the start edge, the output is low and no further edge pulses occur until the next start. This holds even if it cuts a high phase short. A cycle time of 0 gives no clock at all.
- R5: The edge pulse is high for exactly the functional cycle that begins with each output rising edge, and it is low otherwise.
- R6: The error flag updates on the start edge and holds until the next start. It is 1 when the cycle time is less than the activation delay, when (cycle time minus activation delay) is not a multiple of N, or when the page time is not a multiple of N. It is 0 otherwise.
- R7: Changes to the sync flag, divide select, activation delay, cycle time or page time inputs between start pulses have no effect on the access in progress.
- R8: While reset is asserted, and after it is released until the first start, the output clock, edge pulse and error flag are all 0.
- R9: A start pulse arriving during an access abandons it and begins a new one. The new access uses the new configuration, and its counting and phase restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse opening an access and capturing the configuration |
| sync_i | input | 1 | 1 for a synchronous access, 0 for an asynchronous one |
| div_sel_i | input | 2 | Divide select, ratio = value + 1 |
| act_dly_i | input | 2 | Activation delay in functional cycles |
| cyc_time_i | input | CNT_W | Access cycle time in functional cycles |
| page_time_i | input | CNT_W | Page burst access time in functional cycles, checked only |
| ext_clk_o | output | 1 | Clock for the synchronous memory |
| edge_o | output | 1 | High in the functional cycle that starts with an output rising edge |
| cfg_err_o | output | 1 | Configuration rule violated for the current access |

## Verification
A wrong phase count or a wrong divide capture changes the output's high and low widths within one output period after activation. Sampling in both halves of every functional cycle exposes this at half-cycle resolution, and it also moves the edge pulse by a cycle. A cycle counter that is off by one shows up as a late first edge, or as an output that is still high, or already low, on the cycle-time boundary. Stale configuration registers show up on the first access after the inputs change.

// File: rtl/smcg_pkg.sv
package smcg_pkg;
  localparam int unsigned DIV_W = 2;
  localparam int unsigned ACT_W = 2;

  typedef enum logic [DIV_W-1:0] {
    DIV_BY1 = 2'd0,
    DIV_BY2 = 2'd1,
    DIV_BY3 = 2'd2,
    DIV_BY4 = 2'd3
  } div_e;
endpackage

// File: rtl/smcg_seq.sv
module smcg_seq
  import smcg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 sync_i,
  input  logic [DIV_W-1:0]     div_sel_i,
  input  logic [ACT_W-1:0]     act_dly_i,
  input  logic [CNT_W-1:0]     cyc_time_i,
  output logic                 run_d_o,
  output logic                 run_q_o,
  output logic [DIV_W-1:0]     ph_d_o,
  output div_e                 div_d_o,
  output div_e                 div_q_o,
  output logic                 sync_q_o
);
  logic             busy_q, busy_d;
  logic             sync_q, sync_d;
  div_e             div_q, div_d;
  logic [ACT_W-1:0] act_q, act_d;
  logic [CNT_W-1:0] cyc_q, cyc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] ph_q, ph_d;
  logic             run_q, run_d;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W-1:0] act_ext;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign act_ext = {{(CNT_W-ACT_W){1'b0}}, act_d};

  always_comb begin
    sync_d = sync_q;
    div_d  = div_q;
    act_d  = act_q;
    cyc_d  = cyc_q;
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    busy_d = 1'b0;
    if (start_i) begin
      sync_d = sync_i;
      div_d  = div_e'(div_sel_i);
      act_d  = act_dly_i;
      cyc_d  = cyc_time_i;
      cnt_d  = '0;
      ph_d   = '0;
      busy_d = (cyc_time_i != '0);
    end else if (busy_q) begin
      cnt_d  = cnt_inc[CNT_W-1:0];
      busy_d = (cnt_inc < {1'b0, cyc_q});
      if (run_q) ph_d = (ph_q == DIV_W'(div_q)) ? '0 : ph_q + 1'b1;
    end
  end

  assign run_d = busy_d && sync_d && (cnt_d >= act_ext) && (cnt_d < cyc_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sync_q <= 1'b0;
      div_q  <= DIV_BY1;
      act_q  <= '0;
      cyc_q  <= '0;
      cnt_q  <= '0;
      ph_q   <= '0;
      run_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sync_q <= sync_d;
      div_q  <= div_d;
      act_q  <= act_d;
      cyc_q  <= cyc_d;
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      run_q  <= run_d;
    end
  end

  assign run_d_o  = run_d;
  assign run_q_o  = run_q;
  assign ph_d_o   = ph_d;
  assign div_d_o  = div_d;
  assign div_q_o  = div_q;
  assign sync_q_o = sync_q;

  // cycle counter never runs past the captured cycle time
  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < cyc_q));

  // phase stays inside one output period
  assert_phase_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= DIV_W'(div_q));
endmodule

// File: rtl/smcg_div.sv
module smcg_div
  import smcg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_d_i,
  input  logic             run_q_i,
  input  logic [DIV_W-1:0] ph_d_i,
  input  div_e             div_d_i,
  input  div_e             div_q_i,
  output logic             ext_clk_o,
  output logic             edge_o
);
  logic [DIV_W:0]   ratio_d;
  logic [DIV_W-1:0] half_d;
  logic             pos_d;
  logic             pos_q, neg_q, en1_q, edge_q;

  assign ratio_d = {1'b0, div_d_i} + 1'b1;
  assign half_d  = ratio_d[DIV_W:1];
  // high for the first floor(N/2) cycles; divide-by-3 adds the retimed half
  assign pos_d   = run_d_i && (ph_d_i < half_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      edge_q <= run_d_i && (ph_d_i == '0);
    end
  end

  // falling-edge stage: half-cycle extension and divide-by-1 gate enable
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q <= 1'b0;
      en1_q <= 1'b0;
    end else begin
      neg_q <= pos_q;
      en1_q <= run_d_i;
    end
  end

  always_comb begin
    unique case (div_q_i)
      DIV_BY1: ext_clk_o = clk_i & en1_q;
      DIV_BY3: ext_clk_o = pos_q | (neg_q & run_q_i);
      default: ext_clk_o = pos_q;
    endcase
  end

  assign edge_o = edge_q;

  // an edge pulse only inside a running window
  assert_edge_in_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q |-> run_q_i);
endmodule

// File: rtl/smcg_cfg_chk.sv
module smcg_cfg_chk
  import smcg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic [ACT_W-1:0] act_dly_i,
  input  logic [CNT_W-1:0] cyc_time_i,
  input  logic [CNT_W-1:0] page_time_i,
  output logic             err_o
);
  logic [CNT_W-1:0] act_ext, span;
  logic             err_d, err_q;

  function automatic logic fits(logic [CNT_W-1:0] v, logic [DIV_W-1:0] sel);
    unique case (sel)
      2'd0:    fits = 1'b1;
      2'd1:    fits = ~v[0];
      2'd2:    fits = ((v % CNT_W'(3)) == '0);
      default: fits = (v[1:0] == 2'b00);
    endcase
  endfunction

  assign act_ext = {{(CNT_W-ACT_W){1'b0}}, act_dly_i};
  assign span    = cyc_time_i - act_ext;
  assign err_d   = (cyc_time_i < act_ext) || !fits(span, div_sel_i) ||
                   !fits(page_time_i, div_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (start_i) err_q <= err_d;
  end

  assign err_o = err_q;
endmodule

// File: rtl/sync_mem_clk_gen.sv
module sync_mem_clk_gen
  import smcg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sync_i,
  input  logic [1:0]       div_sel_i,
  input  logic [1:0]       act_dly_i,
  input  logic [CNT_W-1:0] cyc_time_i,
  input  logic [CNT_W-1:0] page_time_i,
  output logic             ext_clk_o,
  output logic             edge_o,
  output logic             cfg_err_o
);
  logic             run_d, run_q, sync_q;
  logic [DIV_W-1:0] ph_d;
  div_e             div_d, div_q;

  smcg_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sync_i     (sync_i),
    .div_sel_i  (div_sel_i),
    .act_dly_i  (act_dly_i),
    .cyc_time_i (cyc_time_i),
    .run_d_o    (run_d),
    .run_q_o    (run_q),
    .ph_d_o     (ph_d),
    .div_d_o    (div_d),
    .div_q_o    (div_q),
    .sync_q_o   (sync_q)
  );

  smcg_div u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_d_i   (run_d),
    .run_q_i   (run_q),
    .ph_d_i    (ph_d),
    .div_d_i   (div_d),
    .div_q_i   (div_q),
    .ext_clk_o (ext_clk_o),
    .edge_o    (edge_o)
  );

  smcg_cfg_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .div_sel_i   (div_sel_i),
    .act_dly_i   (act_dly_i),
    .cyc_time_i  (cyc_time_i),
    .page_time_i (page_time_i),
    .err_o       (cfg_err_o)
  );

  // asynchronous access never produces an output edge
  assert_async_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_q |-> !edge_o);

  // for ratios above 1, edge pulses are never back to back without a restart
  assert_edge_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && (div_q != DIV_BY1) && !start_i) |=> !edge_o);
endmodule

// File: tb/sim_sync_mem_clk_gen.sv
module sim_sync_mem_clk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       sync_v = 1'b0;
  logic [1:0] div_v = 2'd0;
  logic [1:0] act_v = 2'd0;
  logic [7:0] cyc_v = 8'd0;
  logic [7:0] page_v = 8'd0;
  logic       ext, edg, err;

  always #4 clk = ~clk;

  sync_mem_clk_gen #(.CNT_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sync_i(sync_v),
    .div_sel_i(div_v), .act_dly_i(act_v), .cyc_time_i(cyc_v),
    .page_time_i(page_v), .ext_clk_o(ext), .edge_o(edg), .cfg_err_o(err)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string req = "R8";

  // behavioural reference
  bit m_on, m_sync, m_err;
  int m_k, m_n, m_act, m_cyc;

  function automatic bit calc_err(int c, int a, int n, int p);
    return (c < a) || (((c - a) % n) != 0) || ((p % n) != 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on = 0; m_sync = 0; m_err = 0; m_k = 0; m_n = 1; m_act = 0; m_cyc = 0;
    end else if (start) begin
      m_on = 1; m_k = 0; m_sync = sync_v; m_n = int'(div_v) + 1;
      m_act = int'(act_v); m_cyc = int'(cyc_v);
      m_err = calc_err(int'(cyc_v), int'(act_v), int'(div_v) + 1, int'(page_v));
    end else if (m_on && m_k < 100000) begin
      m_k++;
    end
  end

  function automatic bit m_run();
    return m_on && m_sync && (m_k >= m_act) && (m_k < m_cyc);
  endfunction

  function automatic bit m_ext(bit second);
    int h;
    h = 2 * (m_k - m_act) + int'(second);
    return m_run() && ((h % (2 * m_n)) < m_n);
  endfunction

  function automatic bit m_edge();
    return m_run() && (((m_k - m_act) % m_n) == 0);
  endfunction

  task automatic check(string what, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  // compare in both halves of every functional cycle
  initial begin
    wait (rst_n);
    forever begin
      @(posedge clk);
      #2;
      check("ext high-half", ext, m_ext(1'b0));
      check("edge", edg, m_edge());
      check("err", err, m_err);
      #4;
      check("ext low-half", ext, m_ext(1'b1));
    end
  end

  task automatic go(bit s, int d, int a, int c, int p);
    @(posedge clk);
    #1;
    sync_v = s; div_v = 2'(d); act_v = 2'(a); cyc_v = 8'(c); page_v = 8'(p);
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R8: reset state, both clock phases
    repeat (2) @(posedge clk);
    #2;
    check("reset ext", ext, 1'b0);
    check("reset edge", edg, 1'b0);
    check("reset err", err, 1'b0);
    #4;
    check("reset ext low", ext, 1'b0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    idle(4);

    req = "R1";
    for (int d = 0; d < 4; d++) begin
      go(1, d, 1, 1 + 4 * (d + 1), 2 * (d + 1));
      idle(4 * (d + 1) + 4);
    end

    req = "R3";
    for (int a = 0; a < 4; a++) begin
      go(1, 2, a, a + 6, 3);
      idle(a + 9);
    end

    req = "R5";
    go(1, 0, 2, 10, 0);
    idle(12);
    go(1, 1, 3, 11, 2);
    idle(13);

    req = "R2";
    go(0, 1, 0, 10, 0);
    idle(13);
    go(0, 0, 1, 7, 0);
    idle(9);

    req = "R4";
    go(1, 3, 0, 6, 4);
    idle(9);
    go(1, 2, 1, 8, 0);
    idle(10);
    go(1, 1, 0, 0, 0);
    idle(4);

    req = "R6";
    go(1, 1, 0, 8, 5);
    idle(10);
    go(1, 0, 3, 2, 0);
    idle(5);
    go(1, 3, 2, 10, 8);
    idle(12);
    go(1, 2, 0, 9, 6);
    idle(11);

    req = "R7";
    go(1, 1, 0, 12, 0);
    sync_v = 1'b0; div_v = 2'd3; act_v = 2'd3; cyc_v = 8'd3; page_v = 8'd1;
    idle(15);

    req = "R9";
    go(1, 3, 1, 20, 0);
    idle(5);
    go(1, 2, 0, 9, 0);
    idle(4);
    go(1, 0, 1, 6, 0);
    idle(9);

    idle(2);
    summary();
    $finish;
  end
endmodule